// File: doc/BRIEF.md
# Successive-Approximation Time-to-Digital Converter Controller

This block is the digital control loop of a time-to-digital converter. It measures a repeating start/stop time gap by binary search. It drives a tap-select code to an external delay-line multiplexer, which delays the start edge by that many unit delays (tau). An external flip-flop samples the delayed start edge on the stop edge and returns a one-bit race decision. The block takes one decision for each repetition of the start/stop pair and fixes one code bit per decision, starting from the most significant bit.

A conversion starts with a start request while the block is idle. Each repetition is announced by a `rep_valid` pulse from the repetition domain. That pulse and the race bit are both brought into the system clock domain through flip-flop chains of equal depth. After N decisions the block pulses `done`, leaves the busy state and holds the final code. The code output is linear in the gap: it equals the number of taps k in 1..2^N-1 whose delay k*tau is strictly shorter than the gap.

Top module: `sar_tdc_ctrl`

## Requirements
- R1: A synchronous reset forces busy=0, done=0, code_out=0 and tap_sel=0.
- R2: A start request while idle sets busy=1, clears code_out to 0 and loads tap_sel with only the most significant bit set (binary 100 for N=3).
- R3: The tap_sel output equals the current trial code. On a decision of 1 the trial bit under test is kept; on 0 it is cleared. The next lower bit is then set for the following trial, so a gap of 4.3 tau gives the sequence 100, 110, 101.
- R4: Each rising edge of the synchronised rep_valid produces exactly one decision, however many clock cycles the pulse stays high.
- R5: On the N-th decision, done is high for exactly one cycle, busy falls in that same cycle, and code_out takes the final code.
- R6: The final code counts the taps k in 1..2^N-1 with k*tau strictly less than the gap, for example 4.3 tau gives 100 and 5.2 tau gives 101. After the conversion, tap_sel keeps the final code.
- R7: A start request while busy has no effect on tap_sel, busy or the progress of the conversion.
- R8: A rep_valid pulse while idle changes neither code_out nor tap_sel, and it raises no done.
- R9: The race bit polarity is 1 when the selected delay is shorter than the measured gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start_req | input | 1 | Begin a conversion (honoured only when idle) |
| rep_valid | input | 1 | Asynchronous pulse, one per start/stop repetition |
| race_bit | input | 1 | Comparator flip-flop output, 1 = delay shorter than gap |
| tap_sel | output | N | Delay tap select to the multiplexer |
| code_out | output | N | Final conversion code |
| done | output | 1 | One-cycle pulse when the last bit is decided |
| busy | output | 1 | Conversion in progress |

## Verification
The cases hardest to reach from the ports are the ones where input arrives at the wrong moment: a start request in the middle of a conversion, and a repetition pulse after the result is final. The stimulus reaches them by stopping the driver after its first repetition to inject a start request, and by sending an extra repetition once done has fired. In both cases the bench then checks tap_sel and code_out against the values predicted from the behavioural delay-line model. Gaps that are not whole multiples of tau, from 0.5 tau to 7.5 tau, cover every output code.

// File: rtl/sar_tdc_ctrl.sv
module sar_tdc_ctrl #(
  parameter int N    = 3,
  parameter int SYNC = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start_req,
  input  logic         rep_valid,
  input  logic         race_bit,
  output logic [N-1:0] tap_sel,
  output logic [N-1:0] code_out,
  output logic         done,
  output logic         busy
);
  localparam logic [N-1:0] TOP = {1'b1, {(N-1){1'b0}}};

  logic [SYNC:0]   vsync;
  logic [SYNC-1:0] rsync;
  logic [N-1:0]    trial, mask, kept;
  logic            step, dec;

  always_ff @(posedge clk) begin
    if (rst) begin
      vsync <= '0;
      rsync <= '0;
    end else begin
      vsync <= {vsync[SYNC-1:0], rep_valid};
      rsync <= {rsync[SYNC-2:0], race_bit};
    end
  end

  assign step    = vsync[SYNC-1] & ~vsync[SYNC];
  assign dec     = rsync[SYNC-1];
  assign kept    = dec ? trial : (trial & ~mask);
  assign tap_sel = trial;

  always_ff @(posedge clk) begin
    if (rst) begin
      trial    <= '0;
      mask     <= '0;
      code_out <= '0;
      done     <= 1'b0;
      busy     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy && start_req) begin
        trial    <= TOP;
        mask     <= TOP;
        code_out <= '0;
        busy     <= 1'b1;
      end else if (busy && step) begin
        mask <= mask >> 1;
        if (mask[0]) begin
          trial    <= kept;
          code_out <= kept;
          done     <= 1'b1;
          busy     <= 1'b0;
        end else begin
          trial <= kept | (mask >> 1);
        end
      end
    end
  end

  assert_start_loads_msb_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (tap_sel == TOP && code_out == '0));
  assert_one_bit_under_test_R3: assert property (@(posedge clk) disable iff (rst)
    busy |-> $onehot(mask));
  assert_done_single_R5: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_done_ends_busy_R5: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  assert_hold_when_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    (busy && !step) |=> $stable(tap_sel) && busy);
  assert_code_only_at_end_R8: assert property (@(posedge clk) disable iff (rst)
    !$stable(code_out) |-> (done || $rose(busy)));
endmodule

// File: tb/sim_sar_tdc_ctrl.sv
module sim_sar_tdc_ctrl;
  localparam int N = 3;
  logic clk = 0, rst = 1, start_req = 0, rep_valid = 0, race_bit = 0;
  logic [N-1:0] tap_sel, code_out;
  logic done, busy;
  int checks = 0, fails = 0, cyc = 0;
  logic [N-1:0] expq[$];
  logic prev_done = 0;

  sar_tdc_ctrl #(.N(N), .SYNC(2)) u0 (.clk(clk), .rst(rst), .start_req(start_req),
    .rep_valid(rep_valid), .race_bit(race_bit), .tap_sel(tap_sel),
    .code_out(code_out), .done(done), .busy(busy));

  always #10 clk = ~clk;

  task automatic chk(string req, int act, int exp_v);
    checks++;
    if (act != exp_v) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  function automatic int expect_code(int gap10);
    int c = 0;
    for (int k = 1; k < (1 << N); k++) if (k * 10 < gap10) c++;
    return c;
  endfunction

  // one repetition: delay-line model decides the race from current tap
  task automatic rep(int gap10);
    @(negedge clk);
    race_bit = (int'(tap_sel) * 10 < gap10);
    rep_valid = 1;
    repeat (4) @(negedge clk);
    rep_valid = 0;
    repeat (6) @(negedge clk);
  endtask

  task automatic begin_conv(int gap10);
    expq.push_back(N'(expect_code(gap10)));
    @(negedge clk); start_req = 1;
    @(negedge clk); start_req = 0;
    chk("R2 busy", busy, 1);
    chk("R2 tap", tap_sel, 1 << (N-1));
    chk("R2 code", code_out, 0);
  endtask

  task automatic convert(int gap10, bool_unused = 0);
    int t, m;
    begin_conv(gap10);
    t = 1 << (N-1); m = t;
    for (int i = 0; i < N; i++) begin
      chk("R3 trial", tap_sel, t);
      if (!(t * 10 < gap10)) t = t & ~m;   // R9 polarity
      m = m >> 1;
      t = t | m;
      rep(gap10);
    end
    chk("R5 idle", busy, 0);
    chk("R6 tap holds final", tap_sel, expect_code(gap10));
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (done) begin
        chk("R5 busy low on done", busy, 0);
        if (expq.size() == 0) chk("R8 unexpected done", 1, 0);
        else chk("R6 final code", code_out, expq.pop_front());
      end
      if (done && prev_done) chk("R5 done one cycle", 1, 0);
    end
    prev_done = done;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 busy", busy, 0); chk("R1 done", done, 0);
    chk("R1 code", code_out, 0); chk("R1 tap", tap_sel, 0);
    rst = 0;
    @(negedge clk);

    convert(43);                       // R6: 4.3 tau -> 100
    chk("R6 4.3tau", code_out, 4);
    convert(52);                       // R6: 5.2 tau -> 101
    chk("R6 5.2tau", code_out, 5);
    for (int g = 5; g < 80; g += 10) convert(g);

    // R8: repetition while idle
    rep(75);
    chk("R8 code", code_out, expect_code(75));
    chk("R8 tap", tap_sel, expect_code(75));

    // R7: start while busy; R4 long pulse counts once
    begin_conv(43);
    rep(43);
    chk("R4 one step", tap_sel, 6);
    @(negedge clk); start_req = 1;
    @(negedge clk); start_req = 0;
    @(negedge clk);
    chk("R7 tap", tap_sel, 6);
    chk("R7 busy", busy, 1);
    @(negedge clk); race_bit = 0; rep_valid = 1;
    repeat (20) @(negedge clk);
    rep_valid = 0;
    repeat (6) @(negedge clk);
    chk("R4 long pulse", tap_sel, 5);
    chk("R4 still busy", busy, 1);
    rep(43);
    chk("R7 result", code_out, 4);

    // R1: reset mid-conversion
    begin_conv(52);
    rep(52);
    expq.delete();
    rst = 1; @(negedge clk); @(negedge clk);
    chk("R1 mid busy", busy, 0);
    chk("R1 mid code", code_out, 0);
    chk("R1 mid tap", tap_sel, 0);
    rst = 0;
    repeat (3) @(negedge clk);
    chk("R5 queue drained", expq.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule